// File: doc/BRIEF.md
# Timer Clock Source Selector

This block decides when a timer counter is allowed to advance. It emits a count-enable tick that lasts one system clock cycle. A 3-bit select input chooses where the tick comes from:

- nothing at all;
- every system clock cycle;
- one of four fixed power-of-two fractions of the system clock, taken from one shared prescaler;
- the edges of an external clock pin.

Everything runs on the single system clock. No clock is gated or muxed.

The external pin never goes through the prescaler. It is resynchronised by a short flop chain and then edge-detected, so each selected edge of the pin gives exactly one tick. The latency is fixed and known. Because the pin is sampled, the external clock has a minimum phase length: each high and each low phase must be longer than two system clocks. The prescaler is a free-running counter shared by all divided taps. Changing the select code therefore never disturbs its phase, and a divided tick always falls on a cycle fixed by the time elapsed since reset.

Top module: `tsel_clock_source`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `cnt_tick` is low. The prescaler restarts from zero when reset is released.
- R2: Select code 000 (stopped) produces no tick.
- R3: Select code 001 produces a tick on every cycle.
- R4: Select codes 010, 011, 100 and 101 give one tick in every 8, 64, 256 and 1024 cycles respectively.
- R5: The prescaler counts every cycle whatever the select code is. A divided tick appears one cycle after a cycle whose count since reset, modulo the ratio, equals ratio minus one.
- R6: Select code 111 gives one tick per rising edge of `ext_clk_in`. Select code 110 gives one tick per falling edge.
- R7: If `ext_clk_in` changes between clock edge k-1 and edge k, the matching tick is high from edge k+2 to edge k+3.
- R8: The external path is never prescaled. The tick count over a window equals the number of selected pin edges, whatever the prescaler phase.
- R9: In the divided and external modes, every tick is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 3 | Tick source select code |
| ext_clk_in | input | 1 | External clock pin, asynchronous to `clk` |
| cnt_tick | output | 1 | Registered one-cycle count enable |

## Verification
The external-path assertions rely on two things: `ext_clk_in` holds each level for more than two system clocks, and `src_sel` changes only between edges. They also take pin history as meaningful only once the synchroniser has been refilled after reset. The bench holds the pin low through reset and keeps every pin phase at least three cycles long. It changes the select code and the pin only on the falling clock edge. The assertion checker ignores the first few cycles after reset, until its own age counter shows that the flop chain holds real samples.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

    localparam int PRESC_W_DEF  = 10;
    localparam int NUM_TAPS     = 4;
    localparam int SEL_W        = 3;

    typedef enum logic [SEL_W-1:0] {
        SRC_OFF      = 3'd0,
        SRC_SYS      = 3'd1,
        SRC_DIV8     = 3'd2,
        SRC_DIV64    = 3'd3,
        SRC_DIV256   = 3'd4,
        SRC_DIV1024  = 3'd5,
        SRC_EXT_FALL = 3'd6,
        SRC_EXT_RISE = 3'd7
    } src_sel_e;

    // number of low prescaler bits that must all be one for tap idx
    function automatic int tap_bits(input int idx);
        case (idx)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

    typedef struct packed {
        logic                sys;
        logic [NUM_TAPS-1:0] div;
        logic                ext_rise;
        logic                ext_fall;
    } tick_bus_t;

endpackage

// File: rtl/tsel_prescaler.sv
module tsel_prescaler
    import tsel_pkg::*;
#(
    parameter int PRESC_W = PRESC_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    output logic [NUM_TAPS-1:0] tap_hit
);

    logic [PRESC_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end

    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
        localparam int B = tap_bits(i);
        assign tap_hit[i] = &count_q[B-1:0];
    end

endmodule

// File: rtl/tsel_ext_sync.sv
module tsel_ext_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_async,
    output logic rise,
    output logic fall
);

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-2:0], pin_async};
            last_q  <= chain_q[SYNC_STAGES-1];
        end
    end

    assign rise =  chain_q[SYNC_STAGES-1] & ~last_q;
    assign fall = ~chain_q[SYNC_STAGES-1] &  last_q;

endmodule

// File: rtl/tsel_src_mux.sv
module tsel_src_mux
    import tsel_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  tick_bus_t        bus,
    output logic             tick
);

    always_comb begin
        case (src_sel_e'(sel))
            SRC_OFF:      tick = 1'b0;
            SRC_SYS:      tick = bus.sys;
            SRC_DIV8:     tick = bus.div[0];
            SRC_DIV64:    tick = bus.div[1];
            SRC_DIV256:   tick = bus.div[2];
            SRC_DIV1024:  tick = bus.div[3];
            SRC_EXT_FALL: tick = bus.ext_fall;
            SRC_EXT_RISE: tick = bus.ext_rise;
            default:      tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/tsel_clock_source.sv
module tsel_clock_source
    import tsel_pkg::*;
#(
    parameter int PRESC_W     = PRESC_W_DEF,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] src_sel,
    input  logic             ext_clk_in,
    output logic             cnt_tick
);

    logic [NUM_TAPS-1:0] tap_hit;
    logic                ext_rise;
    logic                ext_fall;
    tick_bus_t           bus;
    logic                tick_next;
    logic                tick_q;

    tsel_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .tap_hit (tap_hit)
    );

    tsel_ext_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pin_async (ext_clk_in),
        .rise      (ext_rise),
        .fall      (ext_fall)
    );

    always_comb begin
        bus.sys      = 1'b1;
        bus.div      = tap_hit;
        bus.ext_rise = ext_rise;
        bus.ext_fall = ext_fall;
    end

    tsel_src_mux u_mux (
        .sel  (src_sel),
        .bus  (bus),
        .tick (tick_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= 1'b0;
        end else begin
            tick_q <= tick_next;
        end
    end

    assign cnt_tick = tick_q;

endmodule

// File: rtl/tsel_clock_source_chk.sv
module tsel_clock_source_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] src_sel,
    input logic       ext_clk_in,
    input logic       cnt_tick
);

    logic [2:0] age_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= '0;
        end else if (age_q != 3'd7) begin
            age_q <= age_q + 3'd1;
        end
    end

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !cnt_tick);

    // R2
    a_r2_stopped: assert property (@(posedge clk) disable iff (rst)
        (src_sel == 3'd0) |=> !cnt_tick);

    // R3
    a_r3_every_cycle: assert property (@(posedge clk) disable iff (rst)
        (src_sel == 3'd1) |=> cnt_tick);

    // R9: a divided tick never repeats on the next cycle
    a_r9_div_single: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 3'd2 && cnt_tick && src_sel >= 3'd2 && src_sel <= 3'd5
         && $past(src_sel) == src_sel) |=> !cnt_tick);

    // R6: a rising-mode tick implies a real rising edge three to four samples back
    a_r6_rise_source: assert property (@(posedge clk) disable iff (rst)
        (age_q == 3'd7 && $past(src_sel) == 3'd7 && cnt_tick)
        |-> ($past(ext_clk_in, 3) && !$past(ext_clk_in, 4)));

    // R7: a sampled rising edge always yields the tick at the fixed latency
    a_r7_rise_latency: assert property (@(posedge clk) disable iff (rst)
        (age_q == 3'd7 && $past(src_sel) == 3'd7
         && $past(ext_clk_in, 3) && !$past(ext_clk_in, 4)) |-> cnt_tick);

    // R6: falling mode, same latency
    a_r6_fall_latency: assert property (@(posedge clk) disable iff (rst)
        (age_q == 3'd7 && $past(src_sel) == 3'd6
         && !$past(ext_clk_in, 3) && $past(ext_clk_in, 4)) |-> cnt_tick);

endmodule

bind tsel_clock_source tsel_clock_source_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .src_sel    (src_sel),
    .ext_clk_in (ext_clk_in),
    .cnt_tick   (cnt_tick)
);

// File: tb/tsel_clock_source_tb.sv
module tsel_clock_source_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] src_sel = 3'd0;
    logic       ext_clk_in = 1'b0;
    logic       cnt_tick;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    tsel_clock_source u_dut (
        .clk        (clk),
        .rst        (rst),
        .src_sel    (src_sel),
        .ext_clk_in (ext_clk_in),
        .cnt_tick   (cnt_tick)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int cyc = 0;
    bit hist[$];
    bit exp_tick = 0;
    int exp_sel  = 0;

    function automatic string req_of(input int s);
        if (s == 0) return "R2";
        if (s == 1) return "R3";
        if (s <= 5) return "R4/R5";
        return "R6/R7";
    endfunction

    always @(posedge clk) begin
        bit p2, p3;
        if (rst) begin
            cyc = 0;
            hist = {};
            exp_tick = 0;
            exp_sel = 0;
        end else begin
            p2 = (hist.size() > 1) ? hist[1] : 1'b0;
            p3 = (hist.size() > 2) ? hist[2] : 1'b0;
            exp_sel = int'(src_sel);
            case (exp_sel)
                0: exp_tick = 0;
                1: exp_tick = 1;
                2: exp_tick = (cyc % 8) == 7;
                3: exp_tick = (cyc % 64) == 63;
                4: exp_tick = (cyc % 256) == 255;
                5: exp_tick = (cyc % 1024) == 1023;
                6: exp_tick = !p2 && p3;
                default: exp_tick = p2 && !p3;
            endcase
            hist.push_front(ext_clk_in);
            if (hist.size() > 4) void'(hist.pop_back());
            cyc++;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done)
            chk(cnt_tick == exp_tick, req_of(exp_sel), int'(cnt_tick), int'(exp_tick));
    end

    task automatic count_ticks(input int n, output int c);
        c = 0;
        repeat (n) begin
            @(negedge clk);
            c += int'(cnt_tick);
        end
    endtask

    task automatic set_sel(input logic [2:0] s);
        @(negedge clk);
        src_sel = s;
        @(negedge clk);  // first sample still reflects the old code
    endtask

    task automatic toggle_pin(input int edges, input int hold);
        for (int i = 0; i < edges; i++) begin
            repeat (hold) @(negedge clk);
            ext_clk_in = ~ext_clk_in;
        end
    endtask

    initial begin
        int c;
        repeat (3) @(negedge clk);
        chk(cnt_tick == 1'b0, "R1", int'(cnt_tick), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(cnt_tick == 1'b0, "R1", int'(cnt_tick), 0);

        // stopped, prescaler keeps running underneath
        count_ticks(37, c);
        chk(c == 0, "R2", c, 0);

        set_sel(3'd1);
        count_ticks(20, c);
        chk(c == 20, "R3", c, 20);

        // divided taps: the per-cycle model also checks phase (R5)
        set_sel(3'd2);
        count_ticks(8 * 12, c);
        chk(c == 12, "R4", c, 12);
        set_sel(3'd3);
        count_ticks(64 * 5, c);
        chk(c == 5, "R4", c, 5);
        set_sel(3'd0);
        count_ticks(13, c);
        chk(c == 0, "R2", c, 0);
        set_sel(3'd4);
        count_ticks(256 * 3, c);
        chk(c == 3, "R4", c, 3);
        set_sel(3'd5);
        count_ticks(1024 * 2, c);
        chk(c == 2, "R4", c, 2);
        set_sel(3'd2);
        count_ticks(8 * 4, c);
        chk(c == 4, "R5", c, 4);

        // external rising: exact latency and single width
        set_sel(3'd7);
        repeat (5) @(negedge clk);
        ext_clk_in = 1'b1;
        @(negedge clk);
        chk(cnt_tick == 1'b0, "R7", int'(cnt_tick), 0);
        @(negedge clk);
        chk(cnt_tick == 1'b0, "R7", int'(cnt_tick), 0);
        @(negedge clk);
        chk(cnt_tick == 1'b1, "R7", int'(cnt_tick), 1);
        @(negedge clk);
        chk(cnt_tick == 1'b0, "R9", int'(cnt_tick), 0);
        repeat (4) @(negedge clk);
        ext_clk_in = 1'b0;
        repeat (5) @(negedge clk);

        // external rising train: 10 rising edges, no prescaling
        fork
            toggle_pin(20, 3);
            count_ticks(20 * 3 + 6, c);
        join
        chk(c == 10, "R8", c, 10);

        // external falling train, slower phases
        set_sel(3'd6);
        repeat (5) @(negedge clk);
        fork
            toggle_pin(14, 5);
            count_ticks(14 * 5 + 6, c);
        join
        chk(c == 7, "R6", c, 7);

        set_sel(3'd0);
        fork
            toggle_pin(6, 3);
            count_ticks(6 * 3 + 6, c);
        join
        chk(c == 0, "R2", c, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        done = 1;
        fails++;
        tests++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule